// File: doc/BRIEF.md
# MESI Line State Controller

This block holds the coherence state of every line in a small direct-mapped second-level cache. Each line is Modified, Exclusive, Shared or Invalid. Each cycle the block accepts at most one classified event. The event is either a CPU request or a snoop. A CPU request is described by its direction, its cacheability, an allocate flag and a write-through attribute. A snoop carries an invalidate flag and a non-caching-access flag. The block looks up the addressed line, works out the line's next state and writes it back. It also raises the bus and inner-cache action strobes that the event calls for: line fill, replacement write-back of a dirty victim, write-through, snoop write-back, and back-invalidation of the first-level cache.

An address is split into a low index field of `IDX_W` bits and a high tag field of `TAG_W` bits. All results are registered. They appear one clock after the event, with a response valid pulse that tells the consumer when to act. When strobes arrive together in one response, the consumer performs them in a fixed order. A victim write-back goes before the fill. A snoop write-back goes before the back-invalidate. Data storage, bus timing and locked or flush sequences sit outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: any first access reports rsp_hit=0 and rsp_old=0. State codes are I=0, S=1, E=2, M=3.
- R2: A CPU read that hits leaves the line's state unchanged (rsp_new equals rsp_old) and raises no strobe.
- R3: A CPU read miss with cpu_cache=0 raises no strobe, reports rsp_new=I and leaves the stored line at that index untouched.
- R4: A CPU read miss with cpu_cache=1 raises fill_stb and installs the line as E, or as S when cpu_wt=1. If the line it displaces is M, vic_wb_stb is also raised and vic_addr carries {old tag, index}. vic_addr is 0 whenever vic_wb_stb is low.
- R5: A CPU write miss with cpu_alloc=0 raises wthru_stb only, and no line state changes.
- R6: A CPU write miss with cpu_alloc=1 raises fill_stb and installs the line as M. With cpu_wt=1 it installs the line as S and also raises wthru_stb. Victim handling follows R4.
- R7: A CPU write hit on M stays M with no strobe. On E it moves to M silently, or stays E with wthru_stb when cpu_wt=1. On S it stays S with wthru_stb.
- R8: An invalidating snoop hit (snp_inv=1) moves the line to I and raises binv_stb. If the line was M it also raises snp_wb_stb. A snoop miss raises nothing.
- R9: A non-invalidating snoop hit never raises binv_stb. M moves to S with snp_wb_stb. E moves to S, or stays E when snp_nca=1. S stays S.
- R10: When snp_req and cpu_req are both high, only the snoop is handled (rsp_snoop=1). The CPU request is dropped and has no effect on any line.
- R11: Every event gives exactly one rsp_valid pulse on the next clock. A cycle with no request gives rsp_valid=0 and no strobes on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU event present this cycle |
| cpu_wr | input | 1 | CPU event is a write |
| cpu_cache | input | 1 | Read may be cached |
| cpu_alloc | input | 1 | Write miss allocates a line |
| cpu_wt | input | 1 | Write-through attribute |
| cpu_addr | input | IDX_W+TAG_W | CPU address, {tag, index} |
| snp_req | input | 1 | Snoop event present this cycle |
| snp_inv | input | 1 | Snoop invalidates |
| snp_nca | input | 1 | Snooping master does not cache |
| snp_addr | input | IDX_W+TAG_W | Snoop address, {tag, index} |
| rsp_valid | output | 1 | Response for last cycle's event |
| rsp_snoop | output | 1 | Response belongs to a snoop |
| rsp_hit | output | 1 | Addressed line was present |
| rsp_old | output | 2 | Line state before the event (I on miss) |
| rsp_new | output | 2 | Line state after the event |
| fill_stb | output | 1 | Line fill request |
| vic_wb_stb | output | 1 | Write back the replaced M line |
| vic_addr | output | IDX_W+TAG_W | Address of the victim line |
| wthru_stb | output | 1 | Pass the write to the bus |
| snp_wb_stb | output | 1 | Snoop write-back of M data |
| binv_stb | output | 1 | Back-invalidate the inner cache |

## Verification
The assertions take the request flags as meaningful only when the matching request is high. They also assume that each cycle's event is complete in that cycle, with no partial or held requests. The bench drives every flag from $urandom every cycle, whether its request is set or not, so the don't-care flags really do toggle. Tags are drawn from a narrow range so that hits, dirty victims and snoop hits come up often. Simultaneous CPU and snoop requests are generated on purpose to exercise the priority rule.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;

  typedef enum logic [1:0] {
    MS_I = 2'd0,
    MS_S = 2'd1,
    MS_E = 2'd2,
    MS_M = 2'd3
  } mesi_t;

  // One arbitrated event, address carried separately
  typedef struct packed {
    logic valid;
    logic snoop;
    logic wr;
    logic cache;
    logic alloc;
    logic wt;
    logic inv;
    logic nca;
  } mesi_ev_t;

  typedef struct packed {
    mesi_t new_st;
    logic  upd;
    logic  fill;
    logic  vic;
    logic  wthru;
    logic  snp_wb;
    logic  binv;
  } mesi_dec_t;

  // Next state and actions for one event. cur is the stored state at the index.
  function automatic mesi_dec_t mesi_decide(mesi_ev_t ev, logic hit, mesi_t cur);
    mesi_dec_t d;
    d = '0;
    d.new_st = hit ? cur : MS_I;
    if (ev.valid) begin
      if (ev.snoop) begin
        if (hit) begin
          d.upd = 1'b1;
          if (ev.inv) begin
            d.snp_wb = (cur == MS_M);
            d.binv   = 1'b1;
            d.new_st = MS_I;
          end else if (cur == MS_M) begin
            d.snp_wb = 1'b1;
            d.new_st = MS_S;
          end else if (cur == MS_E && !ev.nca) begin
            d.new_st = MS_S;
          end
        end
      end else if (!ev.wr) begin
        if (!hit && ev.cache) begin
          d.upd    = 1'b1;
          d.fill   = 1'b1;
          d.vic    = (cur == MS_M);
          d.new_st = ev.wt ? MS_S : MS_E;
        end
      end else if (hit) begin
        d.upd = 1'b1;
        unique case (cur)
          MS_E: begin
            if (ev.wt) d.wthru = 1'b1;
            else       d.new_st = MS_M;
          end
          MS_S:    d.wthru = 1'b1;
          default: d.new_st = cur;
        endcase
      end else if (ev.alloc) begin
        d.upd    = 1'b1;
        d.fill   = 1'b1;
        d.vic    = (cur == MS_M);
        d.wthru  = ev.wt;
        d.new_st = ev.wt ? MS_S : MS_M;
      end else begin
        d.wthru = 1'b1;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/mesi_tag_store.sv
`timescale 1ns/1ps
module mesi_tag_store
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output mesi_t            rd_st,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  mesi_t            wr_st
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_a [SETS];
  mesi_t            st_a  [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic [TAG_W-1:0] t_q;
    mesi_t            s_q;
    wire              hit_wr = we && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        t_q <= '0;
        s_q <= MS_I;
      end else if (hit_wr) begin
        t_q <= wr_tag;
        s_q <= wr_st;
      end
    end

    assign tag_a[g] = t_q;
    assign st_a[g]  = s_q;
  end

  assign rd_tag = tag_a[rd_idx];
  assign rd_st  = st_a[rd_idx];
endmodule

// File: rtl/mesi_event_arb.sv
`timescale 1ns/1ps
module mesi_event_arb
  import mesi_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          cpu_req,
  input  logic          cpu_wr,
  input  logic          cpu_cache,
  input  logic          cpu_alloc,
  input  logic          cpu_wt,
  input  logic [AW-1:0] cpu_addr,
  input  logic          snp_req,
  input  logic          snp_inv,
  input  logic          snp_nca,
  input  logic [AW-1:0] snp_addr,
  output mesi_ev_t      ev,
  output logic [AW-1:0] ev_addr
);
  // Snoop wins; the CPU request of the same cycle is dropped
  always_comb begin
    ev = '0;
    ev_addr = '0;
    if (snp_req) begin
      ev.valid = 1'b1;
      ev.snoop = 1'b1;
      ev.inv   = snp_inv;
      ev.nca   = snp_nca;
      ev_addr  = snp_addr;
    end else if (cpu_req) begin
      ev.valid = 1'b1;
      ev.wr    = cpu_wr;
      ev.cache = cpu_cache;
      ev.alloc = cpu_alloc;
      ev.wt    = cpu_wt;
      ev_addr  = cpu_addr;
    end
  end
endmodule

// File: rtl/mesi_resolve.sv
`timescale 1ns/1ps
module mesi_resolve
  import mesi_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  mesi_ev_t         ev,
  input  logic [TAG_W-1:0] ev_tag,
  input  logic [TAG_W-1:0] st_tag,
  input  mesi_t            st_state,
  output logic             hit,
  output mesi_dec_t        dec
);
  assign hit = (st_state != MS_I) && (st_tag == ev_tag);
  assign dec = mesi_decide(ev, hit, st_state);
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cpu_req,
  input  logic                   cpu_wr,
  input  logic                   cpu_cache,
  input  logic                   cpu_alloc,
  input  logic                   cpu_wt,
  input  logic [IDX_W+TAG_W-1:0] cpu_addr,
  input  logic                   snp_req,
  input  logic                   snp_inv,
  input  logic                   snp_nca,
  input  logic [IDX_W+TAG_W-1:0] snp_addr,
  output logic                   rsp_valid,
  output logic                   rsp_snoop,
  output logic                   rsp_hit,
  output logic [1:0]             rsp_old,
  output logic [1:0]             rsp_new,
  output logic                   fill_stb,
  output logic                   vic_wb_stb,
  output logic [IDX_W+TAG_W-1:0] vic_addr,
  output logic                   wthru_stb,
  output logic                   snp_wb_stb,
  output logic                   binv_stb
);
  localparam int AW = IDX_W + TAG_W;

  mesi_ev_t         ev;
  logic [AW-1:0]    ev_addr;
  logic [IDX_W-1:0] ev_idx;
  logic [TAG_W-1:0] ev_tag;
  logic [TAG_W-1:0] st_tag;
  mesi_t            st_state;
  logic             lk_hit;
  mesi_dec_t        dec;

  // Named internal event for the checker
  logic             rd_hit_q;

  mesi_event_arb #(.AW(AW)) u_arb (
    .cpu_req  (cpu_req),
    .cpu_wr   (cpu_wr),
    .cpu_cache(cpu_cache),
    .cpu_alloc(cpu_alloc),
    .cpu_wt   (cpu_wt),
    .cpu_addr (cpu_addr),
    .snp_req  (snp_req),
    .snp_inv  (snp_inv),
    .snp_nca  (snp_nca),
    .snp_addr (snp_addr),
    .ev       (ev),
    .ev_addr  (ev_addr)
  );

  assign ev_idx = ev_addr[IDX_W-1:0];
  assign ev_tag = ev_addr[AW-1:IDX_W];

  mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ev_idx),
    .rd_tag (st_tag),
    .rd_st  (st_state),
    .we     (dec.upd),
    .wr_idx (ev_idx),
    .wr_tag (ev_tag),
    .wr_st  (dec.new_st)
  );

  mesi_resolve #(.TAG_W(TAG_W)) u_res (
    .ev      (ev),
    .ev_tag  (ev_tag),
    .st_tag  (st_tag),
    .st_state(st_state),
    .hit     (lk_hit),
    .dec     (dec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_snoop  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_old    <= MS_I;
      rsp_new    <= MS_I;
      fill_stb   <= 1'b0;
      vic_wb_stb <= 1'b0;
      vic_addr   <= '0;
      wthru_stb  <= 1'b0;
      snp_wb_stb <= 1'b0;
      binv_stb   <= 1'b0;
      rd_hit_q   <= 1'b0;
    end else begin
      rsp_valid  <= ev.valid;
      rsp_snoop  <= ev.valid && ev.snoop;
      rsp_hit    <= ev.valid && lk_hit;
      rsp_old    <= (ev.valid && lk_hit) ? st_state : MS_I;
      rsp_new    <= ev.valid ? dec.new_st : MS_I;
      fill_stb   <= dec.fill;
      vic_wb_stb <= dec.vic;
      vic_addr   <= dec.vic ? {st_tag, ev_idx} : '0;
      wthru_stb  <= dec.wthru;
      snp_wb_stb <= dec.snp_wb;
      binv_stb   <= dec.binv;
      rd_hit_q   <= ev.valid && !ev.snoop && !ev.wr && lk_hit;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
`timescale 1ns/1ps
module mesi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_req,
  input logic       snp_req,
  input logic       rsp_valid,
  input logic       rsp_snoop,
  input logic       rsp_hit,
  input logic [1:0] rsp_old,
  input logic [1:0] rsp_new,
  input logic       fill_stb,
  input logic       vic_wb_stb,
  input logic       wthru_stb,
  input logic       snp_wb_stb,
  input logic       binv_stb,
  input logic       rd_hit_q
);
  wire any_stb = fill_stb | vic_wb_stb | wthru_stb | snp_wb_stb | binv_stb;

  // R11
  strobe_has_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> rsp_valid);

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req || snp_req) |=> rsp_valid);

  // R11
  idle_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !snp_req) |=> (!rsp_valid && !any_stb));

  // R10
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_req && cpu_req) |=> (rsp_snoop && !fill_stb && !wthru_stb));

  // R2
  read_hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_q |-> (rsp_new == rsp_old && !any_stb));

  // R4
  victim_with_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_wb_stb |-> (fill_stb && !rsp_hit && !rsp_snoop));

  // R8
  binv_from_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    binv_stb |-> (rsp_snoop && rsp_hit && rsp_new == 2'd0));

  // R7
  dirty_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_snoop && rsp_hit && rsp_old == 2'd3) |-> (rsp_new == 2'd3 && !any_stb));

  // R9
  inquire_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_snoop && rsp_old == 2'd3 && rsp_new == 2'd1) |-> (snp_wb_stb && !binv_stb));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_mesi_line_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .snp_req   (snp_req),
  .rsp_valid (rsp_valid),
  .rsp_snoop (rsp_snoop),
  .rsp_hit   (rsp_hit),
  .rsp_old   (rsp_old),
  .rsp_new   (rsp_new),
  .fill_stb  (fill_stb),
  .vic_wb_stb(vic_wb_stb),
  .wthru_stb (wthru_stb),
  .snp_wb_stb(snp_wb_stb),
  .binv_stb  (binv_stb),
  .rd_hit_q  (rd_hit_q)
);

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
  localparam int IW = 3;
  localparam int TW = 5;
  localparam int AW = IW + TW;
  localparam int NS = 1 << IW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_wr = 0, cpu_cache = 0, cpu_alloc = 0, cpu_wt = 0;
  logic snp_req = 0, snp_inv = 0, snp_nca = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic rsp_valid, rsp_snoop, rsp_hit, fill_stb, vic_wb_stb, wthru_stb, snp_wb_stb, binv_stb;
  logic [1:0] rsp_old, rsp_new;
  logic [AW-1:0] vic_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // bench model: 0=I 1=S 2=E 3=M
  int m_st  [NS];
  int m_tag [NS];

  always #2.5 clk = ~clk;

  mesi_line_ctrl #(.IDX_W(IW), .TAG_W(TW)) i_mesi_line_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_cache(cpu_cache), .cpu_alloc(cpu_alloc),
    .cpu_wt(cpu_wt), .cpu_addr(cpu_addr),
    .snp_req(snp_req), .snp_inv(snp_inv), .snp_nca(snp_nca), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_snoop(rsp_snoop), .rsp_hit(rsp_hit),
    .rsp_old(rsp_old), .rsp_new(rsp_new), .fill_stb(fill_stb), .vic_wb_stb(vic_wb_stb),
    .vic_addr(vic_addr), .wthru_stb(wthru_stb), .snp_wb_stb(snp_wb_stb), .binv_stb(binv_stb)
  );

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  function automatic logic [21:0] pack_act();
    return {rsp_valid, rsp_snoop, rsp_hit, rsp_old, rsp_new, fill_stb, vic_wb_stb,
            wthru_stb, snp_wb_stb, binv_stb, vic_addr, 1'b0};
  endfunction

  // Drive one cycle (called at a negedge), check one cycle later.
  task automatic step(input bit c_rq, input bit c_w, input bit c_c, input bit c_a, input bit c_t,
                      input int c_ad, input bit s_rq, input bit s_i, input bit s_n, input int s_ad);
    string tag_r;
    int idx, tg, cur, ctag, nst;
    bit hit, e_fill, e_vic, e_wt, e_swb, e_binv, upd, snp;
    int e_old;
    logic [AW-1:0] e_vaddr;
    logic [21:0] exp_v;
    cpu_req = c_rq; cpu_wr = c_w; cpu_cache = c_c; cpu_alloc = c_a; cpu_wt = c_t;
    cpu_addr = AW'(c_ad);
    snp_req = s_rq; snp_inv = s_i; snp_nca = s_n; snp_addr = AW'(s_ad);
    snp = s_rq;
    idx = snp ? (s_ad % NS) : (c_ad % NS);
    tg  = snp ? ((s_ad / NS) % (1 << TW)) : ((c_ad / NS) % (1 << TW));
    cur = m_st[idx]; ctag = m_tag[idx];
    hit = (cur != 0) && (ctag == tg);
    e_old = hit ? cur : 0;
    nst = e_old; upd = 0;
    {e_fill, e_vic, e_wt, e_swb, e_binv} = '0;
    e_vaddr = '0;
    tag_r = "R11";
    if (snp) begin
      tag_r = c_rq ? "R10" : (s_i ? "R8" : "R9");
      if (hit) begin
        upd = 1;
        if (s_i) begin
          nst = 0; e_binv = 1; e_swb = (cur == 3);
        end else begin
          case (cur)
            3: begin nst = 1; e_swb = 1; end
            2: nst = s_n ? 2 : 1;
            default: nst = cur;
          endcase
        end
      end
    end else if (c_rq) begin
      if (!c_w && hit) tag_r = "R2";
      else if (!c_w && !c_c) tag_r = "R3";
      else if (!c_w) tag_r = "R4";
      else if (hit) tag_r = "R7";
      else if (!c_a) tag_r = "R5";
      else tag_r = "R6";
      if (hit && c_w) begin
        upd = 1;
        if (cur == 1) e_wt = 1;
        if (cur == 2) begin
          if (c_t) e_wt = 1; else nst = 3;
        end
      end else if (!hit && ((!c_w && c_c) || (c_w && c_a))) begin
        upd = 1; e_fill = 1;
        e_vic = (cur == 3);
        if (e_vic) e_vaddr = AW'(ctag * NS + idx);
        if (c_w) begin nst = c_t ? 1 : 3; e_wt = c_t; end
        else nst = c_t ? 1 : 2;
      end else if (!hit && c_w) begin
        e_wt = 1;
      end
    end
    exp_v = {c_rq | s_rq, snp, (c_rq | s_rq) & hit, 2'(e_old), 2'(nst),
             e_fill, e_vic, e_wt, e_swb, e_binv, e_vaddr, 1'b0};
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (pack_act() !== exp_v) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag_r, pack_act(), exp_v);
    end
    if (upd) begin m_st[idx] = nst; m_tag[idx] = tg; end
  endtask

  function automatic int ad(input int tg, input int ix);
    return tg * NS + ix;
  endfunction

  initial begin
    for (int i = 0; i < NS; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, uncached reads of every index (tag 0 matches reset tags)
    for (int i = 0; i < NS; i++) step(1,0,0,0,0, ad(0,i), 0,0,0,0);
    // R11: idle cycle gives no response
    step(0,0,0,0,0, 0, 0,0,0,0);
    // R4 fill to E, R2 read hit, R7 E->M, R7 M quiet
    step(1,0,1,0,0, ad(3,1), 0,0,0,0);
    step(1,0,1,0,0, ad(3,1), 0,0,0,0);
    step(1,1,0,0,0, ad(3,1), 0,0,0,0);
    step(1,1,0,0,1, ad(3,1), 0,0,0,0);
    // R4 dirty victim on replacement, fill with wt to S
    step(1,0,1,0,1, ad(5,1), 0,0,0,0);
    // R7 write hit on S writes through
    step(1,1,0,0,0, ad(5,1), 0,0,0,0);
    // R5 write miss without allocate
    step(1,1,0,0,0, ad(7,2), 0,0,0,0);
    // R6 allocate to M, then allocate with wt replacing it
    step(1,1,0,1,0, ad(2,2), 0,0,0,0);
    step(1,1,0,1,1, ad(4,2), 0,0,0,0);
    // R3 non-cacheable miss keeps stored S line
    step(1,0,0,0,0, ad(9,2), 0,0,0,0);
    step(1,0,0,0,0, ad(4,2), 0,0,0,0);
    // R8 invalidating snoop on M
    step(1,0,1,0,0, ad(1,3), 0,0,0,0);
    step(1,1,0,0,0, ad(1,3), 0,0,0,0);
    step(0,0,0,0,0, 0, 1,1,0, ad(1,3));
    // R9 inquire on E with nca stays E, without nca goes S, on M writes back
    step(1,0,1,0,0, ad(6,4), 0,0,0,0);
    step(0,0,0,0,0, 0, 1,0,1, ad(6,4));
    step(0,0,0,0,0, 0, 1,0,0, ad(6,4));
    step(1,0,1,0,0, ad(6,5), 0,0,0,0);
    step(1,1,0,0,0, ad(6,5), 0,0,0,0);
    step(0,0,0,0,0, 0, 1,0,0, ad(6,5));
    // R10 both requests: CPU write to the E line dropped, snoop miss elsewhere
    step(1,0,1,0,0, ad(2,6), 0,0,0,0);
    step(1,1,0,0,0, ad(2,6), 1,1,0, ad(8,7));
    step(1,0,0,0,0, ad(2,6), 0,0,0,0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 10;
      bit crq = (r < 8);
      bit srq = (r >= 6);
      int ca = ($urandom % 4) * NS + ($urandom % NS);
      int sa = ($urandom % 4) * NS + ($urandom % NS);
      step(crq, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ca,
           srq, 1'($urandom), 1'($urandom), sa);
    end
    done = 1;
    finish_run();
  end
endmodule